// File: doc/BRIEF.md
# Pipelined Third-Order Cascaded Delta-Sigma Modulator

This block drives the modulus control of a fractional-N feedback divider. A 20-bit fraction word `frac` is read as F / 2^20. On every enabled clock edge the block emits a 3-bit offset code, and the divider adds that offset to its integer ratio. The running mean of the offsets equals the fraction. The quantization noise is pushed towards high frequencies with third-order shaping.

Three first-order accumulators are chained. Each one passes its leftover residue to the next stage. Every 20-bit accumulator is cut into four 5-bit slices, and a one-bit carry register sits between neighbouring slices. The stage-1 operand is skewed slice by slice so that every slice sees its true carry. The later stages take the skewed residue of the stage before them directly. The three top carries are re-timed onto a common cycle and combined by a small cancellation network. That network treats each carry as −1 or 0, so its signed result v lies in −4..3. The result is registered as a 3-bit unsigned code.

When `en` is low the divider runs as a plain integer divider. The output then shows the zero-offset code and every internal register keeps its value.

Top module: `dsm_mash3_pipe`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `ofs_code` is 3 (the zero-offset code), and all internal state is cleared.
- R2: At an edge where `en` is low, `ofs_code` becomes 3 and no internal register changes.
- R3: A stretch of cycles with `en` low is transparent to the sequence: once `en` returns high, the codes continue exactly as if the disabled edges had never happened.
- R4: Counting only enabled edges, the code after enabled edge j equals the ideal cascade's code for the fraction sampled at enabled edge j−7. Codes for earlier indices are 3. In the ideal cascade, stage k adds its input to a 20-bit state, and its carry ck is 1 when the sum reaches 2^20. Stage 1 takes F as input, and stages 2 and 3 take the new state of the stage before them.
- R5: Each carry is mapped to d = −c. The network forms u(n) = d2(n) + d3(n) − d3(n−1) and v(n) = d1(n) + u(n) − u(n−1), with u(0) = 0 and d3(0) = 0. The code is {v[2], ~v[1], ~v[0]}, which equals 3 − v, so the divider offset is code − 3 in −3..4. Code 7 needs c1 = 1, and code 0 needs c1 = 0.
- R6: Over any window of enabled cycles whose sources all had a constant F, the sum of (code − 3) over N cycles differs from N·F/2^20 by less than 4.
- R7: With F = 0, every code is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided reference clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | High: fractional operation; low: zero offset, state frozen |
| frac | input | 20 | Fraction word F, read as F / 2^20 |
| ofs_code | output | 3 | Registered offset code; divider offset = ofs_code − 3 |

## Verification
The hardest behaviour to reach from the ports is the third-stage carry arriving together with a pause. The carry and delay registers of all slices must stop together and then resume without slipping one slice against another, and no average-based check can see such a slip. The stimulus therefore mixes random fractions that change every cycle with enable dropping on about a quarter of the edges. Each code is compared with a plain unpipelined cascade that advances only on enabled edges. Long constant-fraction windows then confirm the mean bound of R6, and directed fractions of zero, one, one half and the full-scale value cover the extreme carry patterns.

// File: rtl/mash3_pkg.sv
package mash3_pkg;

   // Cascade order is fixed by the cancellation network.
   localparam int unsigned MASH_ORDER = 3;

   // Code that tells the divider to add nothing.
   localparam logic [2:0] ZERO_OFS_CODE = 3'd3;

   typedef logic [2:0] ofs_code_t;

   // Signed -4..3 result to unsigned code 3 - v: keep the sign bit,
   // flip the two low bits.
   function automatic ofs_code_t to_ofs_code(input logic [2:0] v);
      return {v[2], ~v[1], ~v[0]};
   endfunction

endpackage

// File: rtl/mash_skew.sv
// Delays slice k of the operand by k enabled cycles, so that the
// low slices run ahead of the high slices by one cycle per slice.
module mash_skew #(
   parameter int unsigned WORD_W  = 20,
   parameter int unsigned SLICE_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);
   localparam int unsigned N_SLICE = WORD_W / SLICE_W;

   for (genvar k = 0; k < N_SLICE; k++) begin : g_sl
      if (k == 0) begin : g_pass
         assign dout[SLICE_W-1:0] = din[SLICE_W-1:0];
      end else begin : g_dly
         logic [k-1:0][SLICE_W-1:0] dl;
         always_ff @(posedge clk) begin
            if (rst) begin
               dl <= '0;
            end else if (en) begin
               dl[0] <= din[k*SLICE_W +: SLICE_W];
               for (int i = 1; i < k; i++) dl[i] <= dl[i-1];
            end
         end
         assign dout[k*SLICE_W +: SLICE_W] = dl[k-1];
      end
   end

endmodule

// File: rtl/mash_pipe_acc.sv
// One first-order stage: a WORD_W accumulator split into slices with
// a registered carry between neighbours. The operand must arrive
// skewed; the residue leaves with the same skew.
module mash_pipe_acc #(
   parameter int unsigned WORD_W  = 20,
   parameter int unsigned SLICE_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [WORD_W-1:0] addend,
   output logic [WORD_W-1:0] resid,
   output logic              carry_out
);
   localparam int unsigned N_SLICE = WORD_W / SLICE_W;

   for (genvar k = 0; k < N_SLICE; k++) begin : g_sl
      logic               cin;
      logic               cr;
      logic [SLICE_W-1:0] st;
      logic [SLICE_W:0]   sum;

      if (k == 0) begin : g_lsb
         assign cin = 1'b0;
      end else begin : g_mid
         assign cin = g_sl[k-1].cr;
      end

      assign sum = {1'b0, st} + {1'b0, addend[k*SLICE_W +: SLICE_W]}
                 + {{SLICE_W{1'b0}}, cin};

      always_ff @(posedge clk) begin
         if (rst) begin
            st <= '0;
            cr <= 1'b0;
         end else if (en) begin
            st <= sum[SLICE_W-1:0];
            cr <= sum[SLICE_W];
         end
      end

      assign resid[k*SLICE_W +: SLICE_W] = st;
   end

   assign carry_out = g_sl[N_SLICE-1].cr;

endmodule

// File: rtl/mash_align.sv
// Re-times the stage carries: stage s is one cycle later than stage
// s-1, so it gets one register fewer.
module mash_align #(
   parameter int unsigned ORDER = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [ORDER-1:0] c_in,
   output logic [ORDER-1:0] c_al
);
   for (genvar s = 0; s < ORDER; s++) begin : g_st
      localparam int unsigned DEPTH = ORDER - s;
      logic [DEPTH-1:0] sh;
      always_ff @(posedge clk) begin
         if (rst) begin
            sh <= '0;
         end else if (en) begin
            sh[0] <= c_in[s];
            for (int i = 1; i < DEPTH; i++) sh[i] <= sh[i-1];
         end
      end
      assign c_al[s] = sh[DEPTH-1];
   end

endmodule

// File: rtl/mash_ecu.sv
// Cancellation with carries read as -1/0: a 2-bit first difference
// stage, a 3-bit second one, then the unsigned code register.
module mash_ecu
   import mash3_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      en,
   input  logic [2:0] c_al,
   output ofs_code_t code
);
   logic       c3_prev;
   logic [1:0] u_prev;
   logic [1:0] u_now;
   logic [2:0] v_now;

   always_comb begin
      // d = -c is {c,c} in two's complement; the result fits in -2..1.
      u_now = {c_al[1], c_al[1]} + {c_al[2], c_al[2]} - {c3_prev, c3_prev};
      // Result fits in -4..3.
      v_now = {3{c_al[0]}} + {u_now[1], u_now} - {u_prev[1], u_prev};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         c3_prev <= 1'b0;
         u_prev  <= '0;
         code    <= ZERO_OFS_CODE;
      end else if (en) begin
         c3_prev <= c_al[2];
         u_prev  <= u_now;
         code    <= to_ofs_code(v_now);
      end else begin
         code    <= ZERO_OFS_CODE;
      end
   end

endmodule

// File: rtl/dsm_mash3_pipe.sv
module dsm_mash3_pipe
   import mash3_pkg::*;
#(
   parameter int unsigned FRAC_W  = 20,
   parameter int unsigned SLICE_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [FRAC_W-1:0] frac,
   output logic [2:0]        ofs_code
);
   if (SLICE_W == 0 || (FRAC_W % SLICE_W) != 0) begin : g_bad_slice
      $error("FRAC_W must be a whole multiple of SLICE_W");
   end
   if (FRAC_W < 2) begin : g_bad_width
      $error("FRAC_W too small for a useful fraction");
   end

   logic [FRAC_W-1:0]     frac_sk;
   logic [FRAC_W-1:0]     resid [MASH_ORDER];
   logic [MASH_ORDER-1:0] carry_raw;
   logic [MASH_ORDER-1:0] carry_al;

   mash_skew #(.WORD_W(FRAC_W), .SLICE_W(SLICE_W)) u_skew (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .din (frac),
      .dout(frac_sk)
   );

   for (genvar s = 0; s < MASH_ORDER; s++) begin : g_stage
      logic [FRAC_W-1:0] addend;
      if (s == 0) begin : g_first
         assign addend = frac_sk;
      end else begin : g_next
         // Residue already carries the slice skew the next stage needs.
         assign addend = resid[s-1];
      end
      mash_pipe_acc #(.WORD_W(FRAC_W), .SLICE_W(SLICE_W)) u_acc (
         .clk      (clk),
         .rst      (rst),
         .en       (en),
         .addend   (addend),
         .resid    (resid[s]),
         .carry_out(carry_raw[s])
      );
   end

   mash_align #(.ORDER(MASH_ORDER)) u_align (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .c_in(carry_raw),
      .c_al(carry_al)
   );

   mash_ecu u_ecu (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .c_al(carry_al),
      .code(ofs_code)
   );

endmodule

// File: rtl/mash3_chk.sv
module mash3_chk (
   input logic       clk,
   input logic       rst,
   input logic       en,
   input logic [2:0] carry_al,
   input logic [2:0] ofs_code
);
   AST_RESET_ZERO_OFS: assert property (@(posedge clk) rst |=> ofs_code == 3'd3); // R1
   AST_IDLE_ZERO_OFS: assert property (@(posedge clk) disable iff (rst) !en |=> ofs_code == 3'd3); // R2
   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(carry_al)); // R2
   AST_LOW_END_NEEDS_C1: assert property (@(posedge clk) disable iff (rst) (en && !carry_al[0]) |=> ofs_code != 3'd7); // R5
   AST_HIGH_END_NO_C1: assert property (@(posedge clk) disable iff (rst) (en && carry_al[0]) |=> ofs_code != 3'd0); // R5
endmodule

bind dsm_mash3_pipe mash3_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .en      (en),
   .carry_al(carry_al),
   .ofs_code(ofs_code)
);

// File: tb/sim_dsm_mash3_pipe.sv
`timescale 1ns/1ps
module sim_dsm_mash3_pipe;
   localparam int LAT = 7;
   localparam longint MOD = 64'd1 << 20;
   localparam int WD_CYCLES = 190000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en = 1'b0;
   logic [19:0] frac = '0;
   logic [2:0]  ofs_code;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // Ideal cascade state.
   longint m_a1, m_a2, m_a3;
   int     m_c3p, m_up;
   int     pipe [LAT];
   longint win_sum;

   always #2 clk = ~clk;

   dsm_mash3_pipe u0 (.clk(clk), .rst(rst), .en(en), .frac(frac), .ofs_code(ofs_code));

   function automatic int ref_step(input longint f);
      int c1, c2, c3, u, v;
      m_a1 = m_a1 + f;    c1 = (m_a1 >= MOD) ? 1 : 0; m_a1 = m_a1 % MOD;
      m_a2 = m_a2 + m_a1; c2 = (m_a2 >= MOD) ? 1 : 0; m_a2 = m_a2 % MOD;
      m_a3 = m_a3 + m_a2; c3 = (m_a3 >= MOD) ? 1 : 0; m_a3 = m_a3 % MOD;
      u = -c2 - c3 + m_c3p;
      v = -c1 + u - m_up;
      m_c3p = c3;
      m_up = u;
      return 3 - v;
   endfunction

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic step(input logic e, input logic [19:0] f, input string tag);
      int expv;
      en = e;
      frac = f;
      @(posedge clk);
      if (e) begin
         expv = pipe[LAT-1];
         for (int i = LAT-1; i > 0; i--) pipe[i] = pipe[i-1];
         pipe[0] = ref_step(longint'(f));
      end else begin
         expv = 3;
      end
      @(negedge clk);
      chk(tag, int'(ofs_code), expv);
      if (e) win_sum += longint'(ofs_code) - 3;
   endtask

   task automatic mean_window(input logic [19:0] f, input int n);
      longint err;
      for (int i = 0; i < 12; i++) step(1'b1, f, "R4 flush");
      win_sum = 0;
      for (int i = 0; i < n; i++) step(1'b1, f, "R4 R5 window");
      err = win_sum * MOD - longint'(n) * longint'(f);
      n_chk++;
      if (err >= 4 * MOD || err <= -4 * MOD) begin
         n_fail++;
         $display("FAIL R6: offset sum got %0d expected about %0d (F=%0d, N=%0d)",
                  win_sum, (longint'(n) * longint'(f)) / MOD, f, n);
      end
   endtask

   initial begin
      int seed_dummy;
      logic prev_en;
      seed_dummy = $urandom(32'd20130);
      m_a1 = 0; m_a2 = 0; m_a3 = 0; m_c3p = 0; m_up = 0;
      for (int i = 0; i < LAT; i++) pipe[i] = 3;
      win_sum = 0;

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 code in reset", int'(ofs_code), 3);
      rst = 1'b0;
      chk("R1 code after reset", int'(ofs_code), 3);

      // R7: zero fraction never moves the divider
      for (int i = 0; i < 60; i++) step(1'b1, 20'd0, "R7 zero fraction");

      // R4/R5: directed extreme fractions
      for (int i = 0; i < 100; i++) step(1'b1, 20'd1, "R4 smallest fraction");
      for (int i = 0; i < 100; i++) step(1'b1, 20'h80000, "R4 half fraction");
      for (int i = 0; i < 100; i++) step(1'b1, 20'hFFFFF, "R4 R5 full-scale fraction");

      // R2/R3: a long pause in the middle of a running sequence
      for (int i = 0; i < 20; i++) step(1'b0, 20'h12345, "R2 paused");
      for (int i = 0; i < 40; i++) step(1'b1, 20'hFFFFF, "R3 resume");

      // Random fractions and random enable
      prev_en = 1'b1;
      for (int i = 0; i < 3000; i++) begin
         logic e;
         logic [19:0] f;
         e = ($urandom % 4) != 0;
         f = 20'($urandom);
         if (i % 250 == 0) f = 20'hFFFFF;
         if (i % 250 == 125) f = 20'd0;
         if (!e) step(e, f, "R2 random pause");
         else if (!prev_en) step(e, f, "R3 random resume");
         else step(e, f, "R4 random fraction");
         prev_en = e;
      end

      // R6: mean over constant-fraction windows
      mean_window(20'h55555, 32768);
      mean_window(20'($urandom), 32768);
      mean_window(20'd3, 16384);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R4: watchdog got no completion expected completion within %0d cycles", WD_CYCLES);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule